// File: doc/BRIEF.md
# Sixteen-Pin GPIO Port with Atomic Set/Clear

This block is a general-purpose I/O port for sixteen pins, controlled over a simple 32-bit word-addressed register bus. Each pin has a 4-bit control nibble: a 2-bit direction/speed field and a 2-bit style field. The sixteen nibbles are split across a low control word (pins 0–7) and a high control word (pins 8–15). The pin controls drive a pad model through four 16-bit vectors: driven value, drive enable, pull enable and pull direction. The block also samples the sixteen pad input levels into an input latch.

Software changes output bits in one of three ways. It can write the whole output word. It can write a set/clear word, which sets and clears chosen bits in a single access with no read-modify-write. It can write a clear-only word. A port clock-enable input gates the whole port. While it is low, nothing is written, nothing is sampled and no bus request completes.

The bus side is a two-state machine. In `ST_IDLE` it waits. The transition *accept* (request present and clock enable high) performs any write, captures read data and moves to `ST_RESP`. In `ST_RESP` the acknowledge is high for one cycle, and the transition *complete* returns it to `ST_IDLE` unconditionally.

Top module: `gpio_port`

Word addresses: 0 low control, 1 high control, 2 input latch, 3 output word, 4 set/clear, 5 clear-only, 6–7 unmapped.

## Requirements
- R1: After reset, both control words read 0x44444444, the output word reads 0, and every pin has drive enable 0 and pull enable 0 (floating input).
- R2: The nibble of pin p sits in the low control word for p<8 and in the high control word otherwise, at bit offset 4·(p mod 8). Direction is in nibble bits [1:0] and style in bits [3:2]. Control words read back exactly as written.
- R3: A pin whose direction field is not 00 and whose style bit 0 is 0 is push-pull: drive enable is 1 and the driven value equals its output bit.
- R4: A pin whose direction field is not 00 and whose style bit 0 is 1 is open-drain: the driven value is 0, and drive enable is the inverse of its output bit.
- R5: A pin with direction 00 has drive enable 0. With style 10 it has pull enable 1, with pull direction equal to its output bit (1 = pull-up, 0 = pull-down). With any other style its pull enable is 0.
- R6: A write to the output word loads bits [15:0]. Bits [31:16] of the output word read as 0.
- R7: A set/clear write sets the output bits marked by 1s in [15:0] and clears the bits marked by 1s in [31:16]. A 0 bit changes nothing, and the set wins when both bits of one pin are 1. The set/clear word reads as 0.
- R8: A clear-only write clears the output bits marked by 1s in [15:0], ignores [31:16], and the clear-only word reads as 0.
- R9: While clock enable is high, the input latch takes the pad levels on every clock edge, and a read returns the latched value. While clock enable is low, the latch holds.
- R10: While clock enable is low, a request is neither accepted nor acknowledged and no register changes. The same request completes once clock enable returns high.
- R11: The acknowledge is high for exactly one cycle, one clock after the accepting edge, with read data valid in that cycle.
- R12: Writes to the input latch or to unmapped addresses change nothing, and unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Port clock enable; gates all activity |
| bus_req | input | 1 | Access request, held until acknowledged |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_ack is high |
| bus_ack | output | 1 | One-cycle access completion |
| pad_in | input | 16 | Pad input levels |
| pad_out | output | 16 | Driven pad value |
| pad_oe | output | 16 | Pad drive enable |
| pad_pull_en | output | 16 | Pull resistor enable |
| pad_pull_up | output | 16 | Pull direction, 1 = up |

## Verification
The hardest case to reach from the ports is a pad change that arrives while the clock enable is low and must stay invisible. Reading the latch needs the enable high, and that enable also restarts sampling. The stimulus therefore changes the pads while gated, waits, and then raises the enable in the same cycle the read is issued. Because the accepting edge captures the latch before the new sample lands, the read must return the value held from before the gap, and a second read must return the new value. Set-wins-over-clear is reached with a single set/clear word that names the same pin in both halves.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int PIN_COUNT    = 16;
    localparam int PINS_PER_CFG = 8;
    localparam int FIELD_W      = 4;
    localparam int DATA_W       = 32;
    localparam int ADDR_W       = 3;
    localparam int CFG_W        = PINS_PER_CFG * FIELD_W;
    localparam logic [FIELD_W-1:0] FIELD_RESET = 4'b0100;

    typedef enum logic {
        ST_IDLE,
        ST_RESP
    } bus_state_t;

    typedef enum logic [2:0] {
        SEL_CFG_LO,
        SEL_CFG_HI,
        SEL_PIN_IN,
        SEL_PIN_OUT,
        SEL_SET_CLR,
        SEL_CLR_ONLY,
        SEL_NONE
    } reg_sel_t;
endpackage

// File: rtl/gpio_bus_fsm.sv
module gpio_bus_fsm
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              req,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output logic              accept,
    output logic              wr_stb,
    output reg_sel_t          sel,
    output logic              ack
);
    bus_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        accept   = 1'b0;
        ack      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req && clk_en) begin
                    accept   = 1'b1;
                    state_nx = ST_RESP;
                end
            end
            ST_RESP: begin
                ack      = 1'b1;
                state_nx = ST_IDLE;
            end
        endcase
    end

    assign wr_stb = accept & wr;

    always_comb begin
        case (addr)
            3'd0:    sel = SEL_CFG_LO;
            3'd1:    sel = SEL_CFG_HI;
            3'd2:    sel = SEL_PIN_IN;
            3'd3:    sel = SEL_PIN_OUT;
            3'd4:    sel = SEL_SET_CLR;
            3'd5:    sel = SEL_CLR_ONLY;
            default: sel = SEL_NONE;
        endcase
    end

    p_ack_follows_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> ack);
    p_ack_one_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
    p_no_ack_when_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !clk_en) |=> !ack);
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clk_en,
    input  logic                 accept,
    input  logic                 wr_stb,
    input  reg_sel_t             sel,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [PIN_COUNT-1:0] pad_in,
    output logic [CFG_W-1:0]     cfg_lo,
    output logic [CFG_W-1:0]     cfg_hi,
    output logic [PIN_COUNT-1:0] odr,
    output logic [DATA_W-1:0]    rdata
);
    localparam logic [CFG_W-1:0] CFG_RESET = {PINS_PER_CFG{FIELD_RESET}};

    logic [PIN_COUNT-1:0] idr;
    logic [DATA_W-1:0]    rd_mux;
    logic [PIN_COUNT-1:0] set_bits, clr_bits;

    assign set_bits = wdata[PIN_COUNT-1:0];
    assign clr_bits = wdata[PIN_COUNT +: PIN_COUNT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_lo <= CFG_RESET;
            cfg_hi <= CFG_RESET;
            odr    <= '0;
            idr    <= '0;
        end else if (clk_en) begin
            idr <= pad_in;
            if (wr_stb) begin
                case (sel)
                    SEL_CFG_LO:   cfg_lo <= wdata;
                    SEL_CFG_HI:   cfg_hi <= wdata;
                    SEL_PIN_OUT:  odr    <= set_bits;
                    SEL_SET_CLR:  odr    <= (odr & ~clr_bits) | set_bits;
                    SEL_CLR_ONLY: odr    <= odr & ~set_bits;
                    default:      ;
                endcase
            end
        end
    end

    always_comb begin
        case (sel)
            SEL_CFG_LO:  rd_mux = cfg_lo;
            SEL_CFG_HI:  rd_mux = cfg_hi;
            SEL_PIN_IN:  rd_mux = DATA_W'(idr);
            SEL_PIN_OUT: rd_mux = DATA_W'(odr);
            default:     rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata <= '0;
        else if (accept) rdata <= rd_mux;
    end

    p_idr_sample_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en |=> (idr == $past(pad_in)));
    p_idr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(idr));
    p_odr_hold_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(odr) && $stable(cfg_lo) && $stable(cfg_hi)));
endmodule

// File: rtl/gpio_pin_decode.sv
module gpio_pin_decode
    import gpio_pkg::*;
(
    input  logic [CFG_W-1:0]     cfg_lo,
    input  logic [CFG_W-1:0]     cfg_hi,
    input  logic [PIN_COUNT-1:0] odr,
    output logic [PIN_COUNT-1:0] pad_out,
    output logic [PIN_COUNT-1:0] pad_oe,
    output logic [PIN_COUNT-1:0] pad_pull_en,
    output logic [PIN_COUNT-1:0] pad_pull_up
);
    logic [2*CFG_W-1:0] cfg_all;
    assign cfg_all = {cfg_hi, cfg_lo};

    for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
        logic [FIELD_W-1:0] nib;
        logic [1:0]         dir, sty;
        logic               is_out;
        assign nib    = cfg_all[p*FIELD_W +: FIELD_W];
        assign dir    = nib[1:0];
        assign sty    = nib[3:2];
        assign is_out = (dir != 2'b00);

        always_comb begin
            pad_out[p]     = 1'b0;
            pad_oe[p]      = 1'b0;
            pad_pull_en[p] = 1'b0;
            pad_pull_up[p] = 1'b0;
            if (is_out) begin
                if (sty[0]) begin
                    pad_oe[p] = ~odr[p];
                end else begin
                    pad_oe[p]  = 1'b1;
                    pad_out[p] = odr[p];
                end
            end else if (sty == 2'b10) begin
                pad_pull_en[p] = 1'b1;
                pad_pull_up[p] = odr[p];
            end
        end
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clk_en,
    input  logic                 bus_req,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 bus_ack,
    input  logic [PIN_COUNT-1:0] pad_in,
    output logic [PIN_COUNT-1:0] pad_out,
    output logic [PIN_COUNT-1:0] pad_oe,
    output logic [PIN_COUNT-1:0] pad_pull_en,
    output logic [PIN_COUNT-1:0] pad_pull_up
);
    logic                 accept, wr_stb;
    reg_sel_t             sel;
    logic [CFG_W-1:0]     cfg_lo, cfg_hi;
    logic [PIN_COUNT-1:0] odr;

    gpio_bus_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
        .req(bus_req), .wr(bus_wr), .addr(bus_addr),
        .accept(accept), .wr_stb(wr_stb), .sel(sel), .ack(bus_ack)
    );

    gpio_regs u_regs (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
        .accept(accept), .wr_stb(wr_stb), .sel(sel), .wdata(bus_wdata),
        .pad_in(pad_in), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .odr(odr),
        .rdata(bus_rdata)
    );

    gpio_pin_decode u_dec (
        .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .odr(odr),
        .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pull_en(pad_pull_en), .pad_pull_up(pad_pull_up)
    );
endmodule

// File: tb/sim_gpio_port.sv
module sim_gpio_port;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en = 1'b1;
    logic        bus_req = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ack;
    logic [15:0] pad_in = '0;
    logic [15:0] pad_out, pad_oe, pad_pull_en, pad_pull_up;

    int n_checks = 0;
    int n_fail   = 0;
    int last_lat = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port u0 (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
        .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pull_en(pad_pull_en), .pad_pull_up(pad_pull_up)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wait_ack();
        last_lat = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            last_lat++;
            if (bus_ack) break;
        end
        bus_req = 1'b0;
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        wait_ack();
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = 1'b0; bus_addr = a;
        wait_ack();
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 oe", 32'(pad_oe), 0);
        check("R1 pull_en", 32'(pad_pull_en), 0);
        bus_read(3'd0, d); check("R1 cfg_lo", d, 32'h44444444);
        bus_read(3'd1, d); check("R1 cfg_hi", d, 32'h44444444);
        bus_read(3'd3, d); check("R1 out", d, 0);
    endtask

    task automatic t_handshake();
        bus_write(3'd3, 32'h0);
        check("R11 latency", 32'(last_lat), 1);
        @(negedge clk);
        check("R11 ack one cycle", 32'(bus_ack), 0);
    endtask

    task automatic t_cfg_layout();
        logic [31:0] d;
        bus_write(3'd0, 32'h12345678);
        bus_read(3'd0, d); check("R2 readback lo", d, 32'h12345678);
        check("R2 oe by nibble", 32'(pad_oe), 32'h00EE);
        check("R2 pull pin0", 32'(pad_pull_en), 32'h0001);
        bus_write(3'd1, 32'h9ABCDEF0);
        bus_read(3'd1, d); check("R2 readback hi", d, 32'h9ABCDEF0);
        bus_write(3'd0, 32'h44444444);
        bus_write(3'd1, 32'h44444444);
    endtask

    task automatic t_pushpull();
        bus_write(3'd1, 32'h44444421);
        bus_write(3'd3, 32'h00000300);
        check("R3 oe", 32'(pad_oe), 32'h0300);
        check("R3 out", 32'(pad_out), 32'h0300);
        bus_write(3'd3, 32'h00000100);
        check("R3 out low", 32'(pad_out), 32'h0100);
        bus_write(3'd1, 32'h44444444);
    endtask

    task automatic t_opendrain();
        bus_write(3'd0, 32'h44444447);
        bus_write(3'd3, 32'h0);
        check("R4 od drive", 32'(pad_oe), 32'h0001);
        check("R4 od value", 32'(pad_out), 0);
        bus_write(3'd3, 32'h1);
        check("R4 od release", 32'(pad_oe), 0);
        check("R4 od value hi", 32'(pad_out), 0);
    endtask

    task automatic t_input_pulls();
        bus_write(3'd0, 32'h44444080);
        bus_write(3'd3, 32'h0002);
        check("R5 oe", 32'(pad_oe), 0);
        check("R5 pull_en", 32'(pad_pull_en), 32'h0002);
        check("R5 pull up", 32'(pad_pull_up), 32'h0002);
        bus_write(3'd3, 32'h0);
        check("R5 pull down", 32'(pad_pull_up), 0);
        bus_write(3'd0, 32'h44444444);
    endtask

    task automatic t_odr();
        logic [31:0] d;
        bus_write(3'd3, 32'hABCD1234);
        bus_read(3'd3, d); check("R6 out word", d, 32'h00001234);
    endtask

    task automatic t_setclr();
        logic [31:0] d;
        bus_write(3'd3, 32'h00F0);
        bus_write(3'd4, 32'h00300003);
        bus_read(3'd3, d); check("R7 set/clear", d, 32'h00C3);
        bus_write(3'd4, 32'h01010100);
        bus_read(3'd3, d); check("R7 set wins", d, 32'h01C2);
        bus_read(3'd4, d); check("R7 reads zero", d, 0);
    endtask

    task automatic t_clronly();
        logic [31:0] d;
        bus_write(3'd5, 32'hFFFF0040);
        bus_read(3'd3, d); check("R8 clear only", d, 32'h0182);
        bus_read(3'd5, d); check("R8 reads zero", d, 0);
    endtask

    task automatic t_sample();
        logic [31:0] d;
        @(negedge clk); pad_in = 16'hA5C3;
        @(negedge clk);
        bus_read(3'd2, d); check("R9 sample", d, 32'hA5C3);
        @(negedge clk); clk_en = 1'b0; pad_in = 16'h1234;
        repeat (3) @(negedge clk);
        clk_en = 1'b1;
        bus_req = 1'b1; bus_wr = 1'b0; bus_addr = 3'd2;
        wait_ack();
        check("R9 held while gated", bus_rdata, 32'hA5C3);
        bus_read(3'd2, d); check("R9 resample", d, 32'h1234);
    endtask

    task automatic t_gate();
        logic [31:0] d;
        @(negedge clk); clk_en = 1'b0;
        bus_req = 1'b1; bus_wr = 1'b1; bus_addr = 3'd3; bus_wdata = 32'hFFFF;
        begin
            int seen = 0;
            repeat (4) begin
                @(negedge clk);
                if (bus_ack) seen++;
            end
            check("R10 no ack gated", 32'(seen), 0);
        end
        check("R10 no write gated", 32'(pad_pull_up), 0);
        clk_en = 1'b1;
        wait_ack();
        check("R10 completes", 32'(last_lat), 1);
        bus_read(3'd3, d); check("R10 write landed", d, 32'hFFFF);
    endtask

    task automatic t_ignored();
        logic [31:0] d;
        @(negedge clk); pad_in = 16'h5A5A;
        bus_write(3'd2, 32'hFFFF0000);
        bus_read(3'd2, d); check("R12 input not writable", d, 32'h5A5A);
        bus_write(3'd7, 32'h0);
        bus_write(3'd6, 32'h0);
        bus_read(3'd3, d); check("R12 unmapped no effect", d, 32'hFFFF);
        bus_read(3'd6, d); check("R12 unmapped reads 0", d, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_handshake();
        t_cfg_layout();
        t_pushpull();
        t_opendrain();
        t_input_pulls();
        t_odr();
        t_setclr();
        t_clronly();
        t_sample();
        t_gate();
        t_ignored();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule